// File: doc/BRIEF.md
# Audio Frame Rate Auto-Detector

This block sits beside a serial audio port and watches its frame-sync and bit-clock inputs. It needs no setup. It measures the time between frame-sync rising edges in cycles of a free-running reference clock and sorts that time into one of twelve sample-rate bands. It also counts the bit-clock rising edges inside each frame. The results are a band index, the bit clocks per frame, a valid flag, a flag for well-behaved ratios, and a lock flag once the measurement has been steady for several frames.

Both inputs are asynchronous to the reference clock. Each passes through a flop synchroniser before edge detection. Each band is stored as a pair of period limits, worked out when the design is elaborated from the reference frequency parameter. No division therefore happens while the block runs. If the frame sync stops for longer than the slowest band allows, the result is withdrawn.

Top module: `frame_rate_detect`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to its idle state: `rate_bucket` = 15, `bclk_ratio` = 0, and `rate_valid`, `ratio_preferred` and `locked` all low.
- R2: Band indices 0 to 11 stand for nominal rates 768, 384, 192, 96, 48, 32, 24, 16, 12, 8, 4.8 and 3 kHz, in that order. Each band accepts a frame rate from about 9% below nominal to 1% above it. In reference cycles, a band accepts a period P with ceil(REF_HZ/f_high) <= P <= floor(REF_HZ/f_low). At the default 49.152 MHz, band 4 accepts 1014 to 1125 cycles, band 0 accepts 64 to 70 and band 11 accepts 16222 to 18004.
- R3: A frame period that lies in no band gives `rate_bucket` = 15 and `rate_valid` low.
- R4: `bclk_ratio` equals the number of bit-clock rising edges from one frame-sync rising edge (included) up to the next (excluded). It saturates at 4095. A 48 kHz-band frame with 20 bit clocks reports 20.
- R5: `rate_valid` is high only when the period lies in a band and the ratio lies in 16 to 2048 inclusive. A ratio of 15 or 2049 gives `rate_valid` low, and the ratio is still reported.
- R6: `ratio_preferred` is high only when `rate_valid` is high and the ratio is one of 16, 20, 24, 32, 40, 48, 64, 96, 128, 256, 512, 1024 or 2048.
- R7: The first frame-sync rising edge after reset or after a timeout only starts a measurement. Each later edge completes one. Suppose a frame-sync rise is first sampled high at reference edge k. Then the outputs change at edge k+3: two synchroniser flops, one measurement register and one result register. Between completions the outputs hold.
- R8: `locked` rises once LOCK_FRAMES (default 4) valid measurements in a row report the same band and ratio. Three in a row do not lock. A differing or invalid measurement clears `locked`, and the count restarts from that measurement.
- R9: If no frame-sync edge comes within TIMEOUT reference cycles of the last one, the outputs return to their idle state. TIMEOUT is the longest band-11 period plus one eighth of it, which is 20254 at the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, free running, at least 4x the fastest bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_in | input | 1 | Frame sync from the audio port, asynchronous |
| bclk_in | input | 1 | Bit clock from the audio port, asynchronous |
| rate_bucket | output | 4 | Detected band index 0..11, or 15 for none |
| bclk_ratio | output | RATIO_W (12) | Bit clocks per frame, saturating |
| rate_valid | output | 1 | Band found and ratio in range |
| ratio_preferred | output | 1 | Valid and ratio on the preferred list |
| locked | output | 1 | Same valid result for LOCK_FRAMES frames in a row |

## Verification
Every result appears on the third reference edge after the edge that first samples a frame-sync rise high. The bench drives both inputs on falling clock edges, so it knows exactly which edge that is. It drives a few cycles past each frame start and checks there. The latency test samples one cycle before and one cycle after the change, which pins the delay to k+3. The lock and timeout checks sit on either side of their thresholds: three matching frames versus four, and a silence of 19900 cycles versus 20400.

// File: rtl/frd_pkg.sv
// Package: shared constants and elaboration-time helpers for the frame rate
// detector. Assumes reference frequencies below a few GHz (longint math).
package frd_pkg;

    localparam int NUM_BUCKETS = 12;
    localparam int BKT_W       = 4;
    localparam logic [BKT_W-1:0] BKT_NONE = 4'hF;

    // Upper edge of each band in units of 10 Hz (index 0 is the fastest band).
    function automatic longint band_hi_10hz(input int idx);
        case (idx)
            0: return 77568;  1: return 38784;  2: return 19392;
            3: return 9696;   4: return 4848;   5: return 3232;
            6: return 2424;   7: return 1616;   8: return 1212;
            9: return 808;   10: return 485;   default: return 303;
        endcase
    endfunction

    // Lower edge of each band in units of 10 Hz.
    function automatic longint band_lo_10hz(input int idx);
        case (idx)
            0: return 69854;  1: return 34927;  2: return 17464;
            3: return 8732;   4: return 4366;   5: return 2911;
            6: return 2183;   7: return 1455;   8: return 1091;
            9: return 728;   10: return 437;   default: return 273;
        endcase
    endfunction

    // Shortest accepted period in reference cycles (rounded up).
    function automatic int band_min_period(input longint ref_hz, input int idx);
        longint d;
        d = band_hi_10hz(idx) * 10;
        return int'((ref_hz + d - 1) / d);
    endfunction

    // Longest accepted period in reference cycles (rounded down).
    function automatic int band_max_period(input longint ref_hz, input int idx);
        return int'(ref_hz / (band_lo_10hz(idx) * 10));
    endfunction

    // Ratios giving the best noise and power behaviour.
    function automatic logic ratio_is_preferred(input int unsigned r);
        case (r)
            16, 20, 24, 32, 40, 48, 64, 96,
            128, 256, 512, 1024, 2048: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/frd_sync_edge.sv
// Synchroniser plus rising-edge detector. Brings an asynchronous input into
// the reference domain through STAGES flops; rise pulses for one cycle.
// Assumes the input stays high and low for at least two reference cycles.
module frd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              last;

    // Shift the input through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
            last <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            last <= pipe[STAGES-1];
        end
    end

    assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/frd_meter.sv
// Frame meter: counts reference cycles and bit-clock edges between frame-sync
// edges. Emits meas_stb with the last frame's counts, or tmo when the frame
// sync goes silent for TIMEOUT cycles. Assumes edge inputs are one-cycle pulses.
module frd_meter #(
    parameter int PER_W   = 15,
    parameter int RATIO_W = 12,
    parameter int TIMEOUT = 20254
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fs_rise,
    input  logic               bc_rise,
    output logic               meas_stb,
    output logic               tmo,
    output logic [PER_W-1:0]   period,
    output logic [RATIO_W-1:0] ratio
);
    localparam logic [PER_W-1:0]   PER_LIMIT = PER_W'(TIMEOUT);
    localparam logic [RATIO_W-1:0] RAT_SAT   = '1;

    logic [PER_W-1:0]   per_cnt;
    logic [RATIO_W-1:0] bc_cnt;
    logic               armed;

    // Count each frame, hand over the counts at the next frame edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt  <= '0;
            bc_cnt   <= '0;
            armed    <= 1'b0;
            meas_stb <= 1'b0;
            tmo      <= 1'b0;
            period   <= '0;
            ratio    <= '0;
        end else begin
            meas_stb <= 1'b0;
            tmo      <= 1'b0;
            if (fs_rise) begin
                if (armed) begin
                    meas_stb <= 1'b1;
                    period   <= per_cnt;
                    ratio    <= bc_cnt;
                end
                armed   <= 1'b1;
                per_cnt <= PER_W'(1);
                bc_cnt  <= bc_rise ? RATIO_W'(1) : '0;
            end else begin
                if (per_cnt != PER_LIMIT) begin
                    per_cnt <= per_cnt + 1'b1;
                end else if (armed) begin
                    tmo   <= 1'b1;
                    armed <= 1'b0;
                end
                if (bc_rise && bc_cnt != RAT_SAT) begin
                    bc_cnt <= bc_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frd_classify.sv
// Classifier: matches a measured period against every band's precomputed
// limits and checks the ratio range and preferred list. Purely combinational.
// Assumes the bands do not overlap at the chosen reference frequency.
module frd_classify #(
    parameter longint REF_HZ    = 49_152_000,
    parameter int     PER_W     = 15,
    parameter int     RATIO_W   = 12,
    parameter int     RATIO_MIN = 16,
    parameter int     RATIO_MAX = 2048
) (
    input  logic [PER_W-1:0]          period,
    input  logic [RATIO_W-1:0]        ratio,
    output logic [frd_pkg::BKT_W-1:0] bucket,
    output logic                      in_bucket,
    output logic                      ratio_ok,
    output logic                      ratio_pref
);
    import frd_pkg::*;

    localparam logic [RATIO_W-1:0] RMIN = RATIO_W'(RATIO_MIN);
    localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(RATIO_MAX);

    logic [NUM_BUCKETS-1:0] hit;

    // One window comparator per band.
    for (genvar i = 0; i < NUM_BUCKETS; i++) begin : g_band
        localparam logic [PER_W-1:0] LO = PER_W'(band_min_period(REF_HZ, i));
        localparam logic [PER_W-1:0] HI = PER_W'(band_max_period(REF_HZ, i));
        assign hit[i] = (period >= LO) && (period <= HI);
    end

    // Encode the matching band, none if no comparator fired.
    always_comb begin
        bucket = BKT_NONE;
        for (int i = 0; i < NUM_BUCKETS; i++) begin
            if (hit[i]) bucket = BKT_W'(i);
        end
    end

    assign in_bucket  = |hit;
    assign ratio_ok   = (ratio >= RMIN) && (ratio <= RMAX);
    assign ratio_pref = ratio_is_preferred(32'(ratio));
endmodule

// File: rtl/frd_lock.sv
// Result register and lock tracker: latches each classified measurement,
// counts consecutive identical valid results, and clears on timeout.
module frd_lock #(
    parameter int RATIO_W     = 12,
    parameter int LOCK_FRAMES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      meas_stb,
    input  logic                      tmo,
    input  logic [frd_pkg::BKT_W-1:0] bucket_in,
    input  logic                      in_bucket,
    input  logic [RATIO_W-1:0]        ratio_in,
    input  logic                      ratio_ok,
    input  logic                      ratio_pref,
    output logic [frd_pkg::BKT_W-1:0] rate_bucket,
    output logic [RATIO_W-1:0]        bclk_ratio,
    output logic                      rate_valid,
    output logic                      ratio_preferred,
    output logic                      locked
);
    import frd_pkg::*;

    localparam int CW = $clog2(LOCK_FRAMES + 1);
    localparam logic [CW-1:0] LOCK_CNT = CW'(LOCK_FRAMES);

    logic [CW-1:0] run_cnt, run_nxt;
    logic          cur_ok, same;

    // Work out the run length of matching valid results.
    always_comb begin
        cur_ok = in_bucket && ratio_ok;
        same   = rate_valid && (bucket_in == rate_bucket) && (ratio_in == bclk_ratio);
        if (!cur_ok)                run_nxt = '0;
        else if (!same)             run_nxt = CW'(1);
        else if (run_cnt == LOCK_CNT) run_nxt = run_cnt;
        else                        run_nxt = run_cnt + 1'b1;
    end

    // Register results on each measurement, clear them on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo) begin
            rate_bucket     <= BKT_NONE;
            bclk_ratio      <= '0;
            rate_valid      <= 1'b0;
            ratio_preferred <= 1'b0;
            locked          <= 1'b0;
            run_cnt         <= '0;
        end else if (meas_stb) begin
            rate_bucket     <= in_bucket ? bucket_in : BKT_NONE;
            bclk_ratio      <= ratio_in;
            rate_valid      <= cur_ok;
            ratio_preferred <= cur_ok && ratio_pref;
            locked          <= (run_nxt == LOCK_CNT);
            run_cnt         <= run_nxt;
        end
    end
endmodule

// File: rtl/frame_rate_detect.sv
// Top: audio frame rate and bit-clock ratio auto-detector. Synchronises the
// frame sync and bit clock, measures each frame, classifies it and tracks
// lock. Assumes clk runs at REF_HZ and at least 4x the fastest bit clock.
module frame_rate_detect #(
    parameter longint REF_HZ      = 49_152_000,
    parameter int     RATIO_W     = 12,
    parameter int     LOCK_FRAMES = 4,
    parameter int     SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync_in,
    input  logic               bclk_in,
    output logic [3:0]         rate_bucket,
    output logic [RATIO_W-1:0] bclk_ratio,
    output logic               rate_valid,
    output logic               ratio_preferred,
    output logic               locked
);
    import frd_pkg::*;

    localparam int SLOW_MAX = band_max_period(REF_HZ, NUM_BUCKETS - 1);
    localparam int TIMEOUT  = SLOW_MAX + SLOW_MAX / 8;
    localparam int PER_W    = $clog2(TIMEOUT + 1);

    logic               fs_rise, bc_rise;
    logic               meas_stb, tmo_pulse;
    logic [PER_W-1:0]   meas_period;
    logic [RATIO_W-1:0] meas_ratio;
    logic [BKT_W-1:0]   cls_bucket;
    logic               cls_in, cls_ok, cls_pref;

    frd_sync_edge #(.STAGES(SYNC_STAGES)) u_fs_sync (
        .clk(clk), .rst_n(rst_n), .din(fsync_in), .rise(fs_rise));

    frd_sync_edge #(.STAGES(SYNC_STAGES)) u_bc_sync (
        .clk(clk), .rst_n(rst_n), .din(bclk_in), .rise(bc_rise));

    frd_meter #(.PER_W(PER_W), .RATIO_W(RATIO_W), .TIMEOUT(TIMEOUT)) u_meter (
        .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .bc_rise(bc_rise),
        .meas_stb(meas_stb), .tmo(tmo_pulse),
        .period(meas_period), .ratio(meas_ratio));

    frd_classify #(.REF_HZ(REF_HZ), .PER_W(PER_W), .RATIO_W(RATIO_W)) u_classify (
        .period(meas_period), .ratio(meas_ratio), .bucket(cls_bucket),
        .in_bucket(cls_in), .ratio_ok(cls_ok), .ratio_pref(cls_pref));

    frd_lock #(.RATIO_W(RATIO_W), .LOCK_FRAMES(LOCK_FRAMES)) u_lock (
        .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .tmo(tmo_pulse),
        .bucket_in(cls_bucket), .in_bucket(cls_in), .ratio_in(meas_ratio),
        .ratio_ok(cls_ok), .ratio_pref(cls_pref),
        .rate_bucket(rate_bucket), .bclk_ratio(bclk_ratio),
        .rate_valid(rate_valid), .ratio_preferred(ratio_preferred),
        .locked(locked));
endmodule

// File: rtl/frd_checker.sv
// Checker: temporal properties of the detector outputs, bound to the top.
module frd_checker #(
    parameter int RATIO_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               meas_stb,
    input logic               tmo_pulse,
    input logic [3:0]         rate_bucket,
    input logic [RATIO_W-1:0] bclk_ratio,
    input logic               rate_valid,
    input logic               ratio_preferred,
    input logic               locked
);
    // R5
    valid_ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> (bclk_ratio >= RATIO_W'(16) && bclk_ratio <= RATIO_W'(2048)));

    // R2
    valid_bucket_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> (rate_bucket < 4'd12));

    // R6
    preferred_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_preferred |-> rate_valid);

    // R8
    lock_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> rate_valid);

    // R8
    lock_rise_on_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_stb));

    // R7
    hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_stb && !tmo_pulse) |=> ($stable(rate_bucket) && $stable(bclk_ratio)
                                       && $stable(rate_valid) && $stable(locked)));

    // R9
    timeout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> (!rate_valid && !locked && !ratio_preferred));
endmodule

bind frame_rate_detect frd_checker #(.RATIO_W(RATIO_W)) u_frd_checker (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .tmo_pulse(tmo_pulse),
    .rate_bucket(rate_bucket), .bclk_ratio(bclk_ratio), .rate_valid(rate_valid),
    .ratio_preferred(ratio_preferred), .locked(locked));

// File: tb/frame_rate_detect_bench.sv
// Directed bench for the frame rate detector. Inputs change on falling edges.
module frame_rate_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync_in = 1'b0;
    logic        bclk_in = 1'b0;
    logic [3:0]  rate_bucket;
    logic [11:0] bclk_ratio;
    logic        rate_valid, ratio_preferred, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frame_rate_detect u_frame_rate_detect (
        .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .bclk_in(bclk_in),
        .rate_bucket(rate_bucket), .bclk_ratio(bclk_ratio), .rate_valid(rate_valid),
        .ratio_preferred(ratio_preferred), .locked(locked));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fsync_in = 1'b0; bclk_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one reference cycle of a frame pattern.
    task automatic drive_cycle(input int c, input int bp);
        @(negedge clk);
        fsync_in = (c < bp);
        bclk_in  = ((c % bp) < (bp / 2));
    endtask

    task automatic run_frames(input int ratio, input int bp, input int n, input int start);
        for (int f = 0; f < n; f++) begin
            for (int c = (f == 0) ? start : 0; c < ratio * bp; c++) drive_cycle(c, bp);
        end
    endtask

    // Start the next frame so the previous one is measured; 6 cycles in.
    task automatic close_frame(input int bp);
        for (int c = 0; c < 6; c++) drive_cycle(c, bp);
    endtask

    task automatic expect_result(input string req, input int bkt, input int rat,
                                 input int vld, input int prf, input int lck);
        chk({req, " bucket"}, rate_bucket, bkt);
        chk({req, " ratio"}, bclk_ratio, rat);
        chk({req, " valid"}, rate_valid, vld);
        chk({req, " preferred"}, ratio_preferred, prf);
        chk({req, " locked"}, locked, lck);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        expect_result("R1 idle", 15, 0, 0, 0, 0);
    endtask

    task automatic t_latency();
        do_reset();
        run_frames(64, 16, 1, 0);
        for (int c = 0; c < 4; c++) drive_cycle(c, 16);
        chk("R7 before k+3 valid", rate_valid, 0);
        drive_cycle(4, 16);
        chk("R7 after k+3 valid", rate_valid, 1);
        chk("R7 after k+3 ratio", bclk_ratio, 64);
    endtask

    task automatic t_example_lock();
        do_reset();
        run_frames(20, 52, 3, 0);
        close_frame(52);
        expect_result("R4 R8 three frames", 4, 20, 1, 1, 0);
        run_frames(20, 52, 1, 6);
        close_frame(52);
        expect_result("R8 four frames", 4, 20, 1, 1, 1);
    endtask

    task automatic t_single(input string req, input int ratio, input int bp,
                            input int bkt, input int vld, input int prf);
        do_reset();
        run_frames(ratio, bp, 1, 0);
        close_frame(bp);
        expect_result(req, bkt, ratio, vld, prf, 0);
    endtask

    task automatic t_mismatch();
        do_reset();
        run_frames(64, 16, 3, 0);
        run_frames(32, 32, 1, 0);
        close_frame(32);
        expect_result("R8 mismatch clears", 4, 32, 1, 1, 0);
        run_frames(32, 32, 3, 6);
        close_frame(32);
        expect_result("R8 relock after restart", 4, 32, 1, 1, 1);
    endtask

    task automatic t_timeout();
        do_reset();
        run_frames(64, 16, 4, 0);
        close_frame(16);
        chk("R9 locked before silence", locked, 1);
        repeat (19900) @(negedge clk);
        chk("R9 still locked before limit", locked, 1);
        repeat (500) @(negedge clk);
        expect_result("R9 after silence", 15, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_example_lock();
        t_single("R6 not preferred 21", 21, 50, 4, 1, 0);
        t_single("R5 ratio 15", 15, 70, 4, 0, 0);
        t_single("R2 fastest band", 16, 4, 0, 1, 1);
        t_single("R2 R5 ratio 2048", 2048, 8, 11, 1, 1);
        t_single("R5 ratio 2049", 2049, 8, 11, 0, 0);
        t_single("R3 gap period 90", 18, 5, 15, 0, 0);
        t_single("R2 low edge 1014", 26, 39, 4, 1, 0);
        t_single("R3 below edge 1012", 22, 46, 15, 0, 0);
        t_single("R2 high edge 1125", 25, 45, 4, 1, 0);
        t_single("R3 above edge 1128", 24, 47, 15, 0, 0);
        t_mismatch();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule